// File: doc/BRIEF.md
# Absolute-Jump Program Counter Unit

This block is the program counter and byte-fetch front end of an 8-bit microcontroller with a 16-bit code space. Every cycle that it is not stalled, it requests one byte from a synchronous program memory, which returns the byte one cycle later together with a valid flag. The block parses the returned stream into instructions. It recognises the two-byte absolute-page jump, the two-byte absolute-page call and the three-byte long jump, and redirects fetching to their targets. Every other opcode is treated as a one-byte instruction.

An absolute-page target combines three parts. The lowest eight bits are the second instruction byte. The next three bits are the top three bits of the opcode. The top five bits are taken from the address that follows the two-byte instruction. Those five bits are latched in the cycle the opcode byte is accepted. The fetch pointer has already run ahead by then and may have wrapped past 0xFFFF, so it is never used for them.

A call presents its return address on a push port for one cycle and then loads the target. Bytes that were already requested when a jump is taken are discarded and never interpreted.

Top module: `pc_jump_unit`

## Requirements
- R1: Out of reset the code address is 0x0000 and the push output is idle.
- R2: Without a taken jump, each unstalled cycle requests the current code address and then advances it by one, modulo 2^16, so 0xFFFF is followed by 0x0000.
- R3: For a two-byte absolute jump or call, target bits 15:11 are bits 15:11 of the instruction address plus two. An absolute jump at 0xFFFC holding bytes 0x01, 0x03 leads to the target 0xF803. One at 0x07FE holding 0x21, 0x10 leads to 0x0910. One at 0x00FC holding 0x01, 0x03 leads to 0x0003.
- R4: A first byte whose low five bits are 00001 is an absolute jump. Target bits 10:8 are its bits 7:5, and target bits 7:0 are the second byte. The code address equals the target in the cycle after the second byte arrives.
- R5: A first byte whose low five bits are 10001 is an absolute call with the same target rule. In the cycle after its second byte arrives, push valid is high for exactly one cycle, the push address is the instruction address plus two, and no fetch is requested. The code address equals the target in the following cycle.
- R6: First byte 0x02 is a long jump. The next code address is the second byte in bits 15:8 and the third byte in bits 7:0, from the cycle after the third byte arrives.
- R7: A byte that was requested before a taken jump or call and that arrives after it is discarded, even when it holds a jump opcode.
- R8: While stall is high, no fetch is requested, no push is signalled, and the code address and all parsing state stay unchanged.
- R9: Any other first byte (for example 0x00, 0x03 or 0xA5) is a one-byte instruction, and parsing continues with the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze the whole unit for this cycle |
| code_addr_o | output | 16 | Code memory read address |
| code_req_o | output | 1 | Read request for code_addr_o this cycle |
| code_rdata_i | input | 8 | Byte returned by the memory |
| code_rvalid_i | input | 1 | code_rdata_i carries a requested byte |
| push_valid_o | output | 1 | Return address is presented this cycle |
| push_addr_o | output | 16 | Return address of an absolute call |

## Verification
The assertions take for granted that the memory answers each unstalled request exactly one cycle later. They also take for granted that, while stall is high, the memory holds its valid flag and data unchanged, so that nothing is lost or duplicated across a stall. The bench models the memory under exactly these rules. It updates the returned byte only in unstalled cycles and never raises valid without an earlier request. The program places jumps at the top of the space, across a 2 KB page edge and near 0x00FC. It also puts jump opcodes in the discarded slots, and random stalls land on every parsing phase, including the push cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
   typedef enum logic [1:0] {
      PH_OPC  = 2'd0,
      PH_ARG1 = 2'd1,
      PH_ARG2 = 2'd2,
      PH_PUSH = 2'd3
   } pcu_phase_e;

   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_ABS  = 2'd1,
      K_CALL = 2'd2,
      K_LONG = 2'd3
   } pcu_kind_e;
endpackage

// File: rtl/pcu_fetch.sv
module pcu_fetch #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall_i,
   input  logic              hold_i,
   input  logic              redirect_i,
   input  logic [ADDR_W-1:0] target_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              req_o,
   output logic              drop_o
);
   logic [ADDR_W-1:0] fa_q;
   logic              drop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fa_q   <= '0;
         drop_q <= 1'b0;
      end else if (!stall_i) begin
         drop_q <= redirect_i;
         if (redirect_i)
            fa_q <= target_i;
         else if (!hold_i)
            fa_q <= fa_q + ADDR_W'(1);
      end
   end

   assign addr_o = fa_q;
   assign req_o  = ~stall_i & ~hold_i;
   assign drop_o = drop_q;

   // R2: sequential step wraps modulo 2^ADDR_W
   a_r2_seq_step : assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !redirect_i) |=> (addr_o == ADDR_W'($past(addr_o) + ADDR_W'(1))));
   // R8: address frozen under stall
   a_r8_stall_hold : assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |=> $stable(addr_o));
   // R4: taken redirect shows up on the address next cycle
   a_r4_redirect_load : assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_i && !stall_i) |=> (addr_o == $past(target_i)));
endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8,
   parameter int TAG_W  = 5,
   localparam int FIELD_W = BYTE_W - TAG_W,
   localparam int PAGE_W  = BYTE_W + FIELD_W,
   localparam int HI_W    = ADDR_W - PAGE_W
) (
   input  logic               sel_long_i,
   input  logic [HI_W-1:0]    hi_i,
   input  logic [FIELD_W-1:0] field_i,
   input  logic [BYTE_W-1:0]  lo_i,
   input  logic [BYTE_W-1:0]  arg1_i,
   input  logic [BYTE_W-1:0]  rdata_i,
   output logic [ADDR_W-1:0]  target_o
);
   logic [ADDR_W-1:0] abs_tgt;
   logic [ADDR_W-1:0] long_tgt;

   assign abs_tgt  = {hi_i, field_i, lo_i};
   assign long_tgt = {arg1_i, rdata_i};
   assign target_o = sel_long_i ? long_tgt : abs_tgt;
endmodule

// File: rtl/pcu_decode.sv
module pcu_decode
   import pcu_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int BYTE_W  = 8,
   parameter int TAG_W   = 5,
   parameter bit CALL_EN = 1'b1,
   parameter logic [TAG_W-1:0]  ABS_TAG  = 5'b00001,
   parameter logic [TAG_W-1:0]  CALL_TAG = 5'b10001,
   parameter logic [BYTE_W-1:0] LONG_OPC = 8'h02,
   localparam int FIELD_W = BYTE_W - TAG_W,
   localparam int PAGE_W  = BYTE_W + FIELD_W,
   localparam int HI_W    = ADDR_W - PAGE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stall_i,
   input  logic               rvalid_i,
   input  logic [BYTE_W-1:0]  rdata_i,
   input  logic               drop_i,
   input  logic [ADDR_W-1:0]  target_i,
   output logic               redirect_o,
   output logic               sel_long_o,
   output logic [HI_W-1:0]    hi_o,
   output logic [FIELD_W-1:0] field_o,
   output logic [BYTE_W-1:0]  lo_o,
   output logic [BYTE_W-1:0]  arg1_o,
   output logic               hold_o,
   output logic               push_valid_o,
   output logic [ADDR_W-1:0]  push_addr_o
);
   pcu_phase_e        phase_q;
   pcu_kind_e         kind_q, kind_nx;
   logic [BYTE_W-1:0] op_q, arg1_q;
   logic [ADDR_W-1:0] ret_q, ia_q;
   logic              is_abs, is_call, is_long, consume;

   assign is_abs  = (rdata_i[TAG_W-1:0] == ABS_TAG);
   assign is_long = (rdata_i == LONG_OPC);

   generate
      if (CALL_EN) begin : g_call
         assign is_call = (rdata_i[TAG_W-1:0] == CALL_TAG);
      end else begin : g_nocall
         assign is_call = 1'b0;
      end
   endgenerate

   always_comb begin
      if (is_long)      kind_nx = K_LONG;
      else if (is_abs)  kind_nx = K_ABS;
      else if (is_call) kind_nx = K_CALL;
      else              kind_nx = K_NONE;
   end

   assign consume    = rvalid_i & ~drop_i & (phase_q != PH_PUSH);
   assign redirect_o = (phase_q == PH_PUSH)
                     | (consume & (phase_q == PH_ARG2))
                     | (consume & (phase_q == PH_ARG1) & (kind_q == K_ABS));
   assign sel_long_o   = (phase_q == PH_ARG2);
   assign hi_o         = ret_q[ADDR_W-1:PAGE_W];
   assign field_o      = op_q[BYTE_W-1:TAG_W];
   assign lo_o         = (phase_q == PH_PUSH) ? arg1_q : rdata_i;
   assign arg1_o       = arg1_q;
   assign hold_o       = (phase_q == PH_PUSH);
   assign push_valid_o = hold_o & ~stall_i;
   assign push_addr_o  = ret_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OPC;
         kind_q  <= K_NONE;
         op_q    <= '0;
         arg1_q  <= '0;
         ret_q   <= '0;
         ia_q    <= '0;
      end else if (!stall_i) begin
         case (phase_q)
            PH_OPC: if (consume) begin
               op_q   <= rdata_i;
               ret_q  <= ia_q + ADDR_W'(2);
               ia_q   <= ia_q + ADDR_W'(1);
               kind_q <= kind_nx;
               if (kind_nx != K_NONE) phase_q <= PH_ARG1;
            end
            PH_ARG1: if (consume) begin
               arg1_q <= rdata_i;
               ia_q   <= ia_q + ADDR_W'(1);
               case (kind_q)
                  K_CALL:  phase_q <= PH_PUSH;
                  K_LONG:  phase_q <= PH_ARG2;
                  default: phase_q <= PH_OPC;
               endcase
            end
            PH_ARG2: if (consume) phase_q <= PH_OPC;
            default: phase_q <= PH_OPC;
         endcase
         if (redirect_o) ia_q <= target_i;
      end
   end

   // R5: call return slot lasts one cycle
   a_r5_push_single : assert property (@(posedge clk) disable iff (!rst_n)
      push_valid_o |=> !push_valid_o);
   // R5: return address equals the byte stream position after the call
   a_r5_ret_addr : assert property (@(posedge clk) disable iff (!rst_n)
      hold_o |-> (push_addr_o == ia_q));
   // R7: the byte arriving after a taken redirect is never parsed
   a_r7_drop_after_redirect : assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_o && !stall_i) |=> !consume);
endmodule

// File: rtl/pc_jump_unit.sv
module pc_jump_unit
   import pcu_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int BYTE_W  = 8,
   parameter int TAG_W   = 5,
   parameter bit CALL_EN = 1'b1,
   parameter logic [TAG_W-1:0]  ABS_TAG  = 5'b00001,
   parameter logic [TAG_W-1:0]  CALL_TAG = 5'b10001,
   parameter logic [BYTE_W-1:0] LONG_OPC = 8'h02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall_i,
   output logic [ADDR_W-1:0] code_addr_o,
   output logic              code_req_o,
   input  logic [BYTE_W-1:0] code_rdata_i,
   input  logic              code_rvalid_i,
   output logic              push_valid_o,
   output logic [ADDR_W-1:0] push_addr_o
);
   localparam int FIELD_W = BYTE_W - TAG_W;
   localparam int PAGE_W  = BYTE_W + FIELD_W;
   localparam int HI_W    = ADDR_W - PAGE_W;

   generate
      if (ADDR_W != 2 * BYTE_W) begin : g_bad_long
         $error("pc_jump_unit: long jump needs ADDR_W == 2*BYTE_W");
      end
      if (TAG_W >= BYTE_W || TAG_W < 1) begin : g_bad_tag
         $error("pc_jump_unit: TAG_W must lie in 1..BYTE_W-1");
      end
      if (HI_W < 1) begin : g_bad_page
         $error("pc_jump_unit: page field leaves no upper address bits");
      end
      if (CALL_EN && ABS_TAG == CALL_TAG) begin : g_bad_codes
         $error("pc_jump_unit: jump and call tags must differ");
      end
   endgenerate

   logic               redirect, sel_long, hold, drop;
   logic [HI_W-1:0]    hi;
   logic [FIELD_W-1:0] field;
   logic [BYTE_W-1:0]  lo, arg1;
   logic [ADDR_W-1:0]  target;

   pcu_fetch #(.ADDR_W(ADDR_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .hold_i(hold),
      .redirect_i(redirect), .target_i(target),
      .addr_o(code_addr_o), .req_o(code_req_o), .drop_o(drop)
   );

   pcu_decode #(
      .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .TAG_W(TAG_W), .CALL_EN(CALL_EN),
      .ABS_TAG(ABS_TAG), .CALL_TAG(CALL_TAG), .LONG_OPC(LONG_OPC)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
      .rvalid_i(code_rvalid_i), .rdata_i(code_rdata_i), .drop_i(drop),
      .target_i(target), .redirect_o(redirect), .sel_long_o(sel_long),
      .hi_o(hi), .field_o(field), .lo_o(lo), .arg1_o(arg1), .hold_o(hold),
      .push_valid_o(push_valid_o), .push_addr_o(push_addr_o)
   );

   pcu_target #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .TAG_W(TAG_W)) u_target (
      .sel_long_i(sel_long), .hi_i(hi), .field_i(field), .lo_i(lo),
      .arg1_i(arg1), .rdata_i(code_rdata_i), .target_o(target)
   );

   // R8: no request and no push while stalled
   a_r8_quiet_in_stall : assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |-> (!code_req_o && !push_valid_o));
   // R5: the push cycle issues no fetch and the target follows
   a_r5_push_then_target : assert property (@(posedge clk) disable iff (!rst_n)
      push_valid_o |-> !code_req_o);
endmodule

// File: tb/pc_jump_unit_bench.sv
module pc_jump_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall_i = 1'b0;
   logic [15:0] code_addr_o;
   logic        code_req_o;
   logic [7:0]  code_rdata_i = 8'h00;
   logic        code_rvalid_i = 1'b0;
   logic        push_valid_o;
   logic [15:0] push_addr_o;

   always #4 clk = ~clk;

   pc_jump_unit u_pc_jump_unit (
      .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
      .code_addr_o(code_addr_o), .code_req_o(code_req_o),
      .code_rdata_i(code_rdata_i), .code_rvalid_i(code_rvalid_i),
      .push_valid_o(push_valid_o), .push_addr_o(push_addr_o)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   logic [7:0] mem [int];
   int    req_log [$];
   bit    logging = 1'b1;

   // behavioural reference state
   int m_fa, m_ia, m_phase, m_op, m_arg, m_ret;
   int inf_a [$];
   bit inf_s [$];

   function automatic logic [7:0] rd(input int a);
      if (mem.exists(a)) return mem[a];
      return 8'h00;
   endfunction

   function automatic int abs_target(input int ret, input int op, input int lo);
      return (ret & 16'hF800) | (((op >> 5) & 7) << 8) | (lo & 255);
   endfunction

   task automatic check(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic int next_after(input int a);
      for (int i = 0; i + 1 < req_log.size(); i++)
         if (req_log[i] == a) return req_log[i + 1];
      return -1;
   endfunction

   task automatic model_step(input bit st, input bit rv, input int rb, input bit rq);
      int  ph;
      bit  use_b, redir, to_push;
      int  tgt;
      if (st) return;
      ph = m_phase; use_b = 0; redir = 0; to_push = 0; tgt = 0;
      if (rv && inf_a.size() > 0) begin
         use_b = !inf_s[0] && ph != 3;
         void'(inf_a.pop_front());
         void'(inf_s.pop_front());
      end
      case (ph)
         0: if (use_b) begin
               m_op = rb; m_ret = (m_ia + 2) & 16'hFFFF; m_ia = (m_ia + 1) & 16'hFFFF;
               if ((rb & 31) == 1 || (rb & 31) == 17 || rb == 2) m_phase = 1;
            end
         1: if (use_b) begin
               m_arg = rb; m_ia = (m_ia + 1) & 16'hFFFF;
               if (m_op == 2) m_phase = 2;
               else if ((m_op & 31) == 17) begin m_phase = 3; to_push = 1; end
               else begin redir = 1; tgt = abs_target(m_ret, m_op, rb); end
            end
         2: if (use_b) begin redir = 1; tgt = (m_arg << 8) | rb; end
         default: begin redir = 1; tgt = abs_target(m_ret, m_op, m_arg); end
      endcase
      if (rq) begin inf_a.push_back(m_fa); inf_s.push_back(1'b0); end
      if (redir || to_push)
         foreach (inf_s[i]) inf_s[i] = 1'b1;
      if (redir) begin m_fa = tgt; m_ia = tgt; m_phase = 0; end
      else if (rq) m_fa = (m_fa + 1) & 16'hFFFF;
   endtask

   task automatic cycle(input bit st);
      bit ereq, epush, rq_c;
      int a_c;
      stall_i = st;
      #1;
      ereq  = !st && m_phase != 3;
      epush = !st && m_phase == 3;
      n_chk++;
      if (code_addr_o !== 16'(m_fa) || code_req_o !== ereq || push_valid_o !== epush ||
          (epush && push_addr_o !== 16'(m_ret))) begin
         n_bad++;
         $display("FAIL %s cycle compare: addr=%h/%h req=%b/%b push=%b/%b paddr=%h/%h",
                  cur_req, code_addr_o, 16'(m_fa), code_req_o, ereq, push_valid_o, epush,
                  push_addr_o, 16'(m_ret));
      end
      rq_c = code_req_o; a_c = code_addr_o;
      if (logging && rq_c) req_log.push_back(a_c);
      @(posedge clk); #1;
      model_step(st, code_rvalid_i, code_rdata_i, ereq);
      if (!st) begin
         code_rvalid_i = rq_c;
         code_rdata_i  = rd(a_c);
      end
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int held;
      // program image
      mem[16'h0000] = 8'h02; mem[16'h0001] = 8'hFF; mem[16'h0002] = 8'hFC; // R6 long jump
      mem[16'hFFFC] = 8'h01; mem[16'hFFFD] = 8'h03;                       // R3 wrap case
      mem[16'hF803] = 8'h02; mem[16'hF804] = 8'h07; mem[16'hF805] = 8'hFE;
      mem[16'h07FE] = 8'h21; mem[16'h07FF] = 8'h10;                       // R3 page crossing
      mem[16'h0800] = 8'h02;                                              // R7 bait
      mem[16'h0912] = 8'h11; mem[16'h0913] = 8'h34;                       // R5 call
      mem[16'h0914] = 8'h02;                                              // R7 bait
      mem[16'h0834] = 8'hA5;                                              // R9
      mem[16'h0835] = 8'h02; mem[16'h0836] = 8'h00; mem[16'h0837] = 8'hFC;
      mem[16'h00FC] = 8'h01; mem[16'h00FD] = 8'h03;                       // R3 low page
      mem[16'h0003] = 8'h02; mem[16'h0004] = 8'hFF; mem[16'h0005] = 8'hFD;
      m_fa = 0; m_ia = 0; m_phase = 0; m_op = 0; m_arg = 0; m_ret = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(code_addr_o == 16'h0000, "R1 reset address", code_addr_o, 0);
      check(push_valid_o == 1'b0, "R1 push idle", push_valid_o, 0);

      cur_req = "R2";
      for (int i = 0; i < 150; i++) cycle(1'b0);
      logging = 1'b0;

      check(next_after(16'h0002) == 16'h0003, "R6 byte order", next_after(16'h0002), 16'h0003);
      check(next_after(16'h0003) == 16'hFFFC, "R6 long target", next_after(16'h0003), 16'hFFFC);
      check(next_after(16'hFFFE) == 16'hF803, "R3 top-of-space jump", next_after(16'hFFFE), 16'hF803);
      check(next_after(16'h0800) == 16'h0910, "R3 page-crossing jump", next_after(16'h0800), 16'h0910);
      check(next_after(16'h0910) == 16'h0911, "R7 bait at 0800 dropped", next_after(16'h0910), 16'h0911);
      check(next_after(16'h0914) == 16'h0834, "R5 call target", next_after(16'h0914), 16'h0834);
      check(next_after(16'h0834) == 16'h0835, "R9 single-byte opcode", next_after(16'h0834), 16'h0835);
      check(next_after(16'h00FE) == 16'h0003, "R4 jump near 00FC", next_after(16'h00FE), 16'h0003);
      check(next_after(16'hFFFF) == 16'h0000, "R2 wrap to zero", next_after(16'hFFFF), 16'h0000);

      cur_req = "R8";
      held = code_addr_o;
      for (int i = 0; i < 3; i++) begin
         cycle(1'b1);
         check(code_addr_o == 16'(held), "R8 address held", code_addr_o, held);
      end

      cur_req = "R5";
      for (int i = 0; i < 400; i++) cycle(($urandom_range(0, 99) < 30) ? 1'b1 : 1'b0);
      for (int i = 0; i < 20; i++) cycle(1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule